// File: doc/BRIEF.md
# Xon/Xoff Software Flow Control Engine

This block sits between the receive deframer and the receive FIFO of a serial port, and between the transmit FIFO and the transmit shifter. Each received character is compared against four programmable flow codes. A stop sequence sets a suspend flag that keeps further FIFO characters from being loaded into the transmitter. A resume sequence clears that flag. A sequence is one character in single mode and two consecutive characters in double mode. Characters consumed as flow control are dropped rather than passed on to the receive FIFO.

On the transmit side, the engine watches the receive FIFO fill level against a trigger level. When the level reaches the trigger, it injects the stop code(s) into the outgoing stream. When the level falls back below the trigger, it injects the resume code(s). Injected characters take precedence over queued data, but they are loaded only when the transmitter reports a character boundary.

A separate special-character mode compares each character with the second stop code. On a match it raises a strobe and keeps the character in the data stream.

Top module: `xonxoff_flow_ctl`

## Requirements
- R1: After reset all four code registers (selector 0 = resume 1, 1 = resume 2, 2 = stop 1, 3 = stop 2) hold zero, so with no writes a received 0x00 in single flow mode is taken as a stop character.
- R2: A comparison uses only the low 5, 6, 7 or 8 bits for word-length codes 0, 1, 2, 3; bit 0 of a code is compared with bit 0 (the first received bit) of the character.
- R3: In single mode a match on stop 1 sets `xoff_rcvd` one cycle after the character and a match on resume 1 clears it; the flag stays set until a resume match, and while set no transmit-queue character is loaded or popped.
- R4: In double mode a stop is recognised only for stop 1 followed by stop 2 in consecutive characters, and a resume only for resume 1 followed by resume 2.
- R5: In double mode, a first-code match followed by a non-matching character pushes the held first character in the cycle after the second arrives. The second character is then re-evaluated: it becomes the new held character if it matches a first code, and otherwise it is pushed one cycle later. `rx_valid` never pulses in two consecutive cycles.
- R6: A character that completes a flow sequence, or is held as the first of one, is never pushed; completion pulses `rx_drop` in the cycle after that character.
- R7: With special mode on, every character is pushed in the next cycle, `spec_hit` pulses with it when the character equals stop 2, and stop/resume matching is off regardless of `flow_en`.
- R8: With flow matching and special mode off, every character is pushed unchanged in the next cycle.
- R9: With injection enabled, a fill level at or above the trigger makes the engine send the stop code(s) and set `peer_paused`; once paused, a level below the trigger makes it send the resume code(s) and clear `peer_paused`.
- R10: A pending injection is loaded ahead of any queued character, only in a cycle with `tx_ready` high; it is resume/stop 1 alone in single mode, and code 1 then code 2 in double mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_we | input | 1 | Code register write strobe |
| code_sel | input | 2 | Code select: 0 resume 1, 1 resume 2, 2 stop 1, 3 stop 2 |
| code_din | input | 8 | Code write data |
| wlen | input | 2 | Word length: 0..3 means 5..8 bits |
| flow_en | input | 1 | Enable stop/resume matching on received data |
| dbl_mode | input | 1 | Two-character sequences for matching and injection |
| spec_mode | input | 1 | Special-character detection mode |
| auto_xmit_en | input | 1 | Enable stop/resume injection from fill level |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_push | output | 1 | Write `rx_out` into the receive FIFO |
| rx_out | output | 8 | Character for the receive FIFO |
| rx_drop | output | 1 | Flow sequence consumed and discarded |
| spec_hit | output | 1 | Special character seen (with its push) |
| xoff_rcvd | output | 1 | Local transmitter suspended by the remote end |
| fifo_level | input | LVL_W | Receive FIFO fill count |
| trig_level | input | LVL_W | Receive trigger level |
| peer_paused | output | 1 | Stop sent to the remote end, resume not yet sent |
| tx_ready | input | 1 | Transmitter at a character boundary, can load |
| txq_valid | input | 1 | Transmit queue holds a character |
| txq_char | input | 8 | Head of the transmit queue |
| tx_load | output | 1 | Load `tx_data` into the transmitter |
| tx_data | output | 8 | Character to transmit |
| txq_pop | output | 1 | Pop the transmit queue head |

## Verification
The hardest case to reach is the double-mode release path. A first code must be followed by a character that breaks the sequence and is itself another first code, or is plain data that needs the delayed second push. Random streams are therefore drawn mostly from the programmed codes, with random bits set above the active word length. This makes such back-to-back partial matches frequent under all four word lengths. Directed sequences pin down the exact release order and the injection ordering at `tx_ready`.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    localparam int CHAR_W = 8;

    typedef logic [CHAR_W-1:0] char_t;

    typedef enum logic [1:0] {
        SEL_ON1  = 2'd0,
        SEL_ON2  = 2'd1,
        SEL_OFF1 = 2'd2,
        SEL_OFF2 = 2'd3
    } code_sel_e;

    typedef struct packed {
        char_t on1;
        char_t on2;
        char_t off1;
        char_t off2;
    } codes_t;

    typedef enum logic [1:0] {
        INJ_IDLE   = 2'd0,
        INJ_FIRST  = 2'd1,
        INJ_SECOND = 2'd2
    } inj_state_e;

    // active bits for word length code 0..3 (5..8 bits)
    function automatic char_t len_mask(input logic [1:0] wl);
        return char_t'(8'hFF >> (2'd3 - wl));
    endfunction

    function automatic logic code_eq(input char_t a, input char_t b,
                                     input logic [1:0] wl);
        return ((a ^ b) & len_mask(wl)) == '0;
    endfunction

endpackage

// File: rtl/xfc_code_regs.sv
module xfc_code_regs
    import xfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [1:0]  sel,
    input  char_t       din,
    output codes_t      codes
);

    always_ff @(posedge clk) begin
        if (rst) begin
            codes <= '0;
        end else if (we) begin
            case (code_sel_e'(sel))
                SEL_ON1:  codes.on1  <= din;
                SEL_ON2:  codes.on2  <= din;
                SEL_OFF1: codes.off1 <= din;
                default:  codes.off2 <= din;
            endcase
        end
    end

    AST_CODES_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (codes == '0)); // R1

endmodule

// File: rtl/xfc_rx_match.sv
module xfc_rx_match
    import xfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  codes_t      codes,
    input  logic [1:0]  wlen,
    input  logic        flow_en,
    input  logic        dbl_mode,
    input  logic        spec_mode,
    input  logic        rx_valid,
    input  char_t       rx_char,
    output logic        rx_push,
    output char_t       rx_out,
    output logic        rx_drop,
    output logic        spec_hit,
    output logic        xoff_rcvd
);

    logic  held_v, held_off, rep_v;
    char_t held_ch, rep_ch;
    logic  m_off1, m_on1, m_second;

    always_comb begin
        m_off1   = code_eq(rx_char, codes.off1, wlen);
        m_on1    = code_eq(rx_char, codes.on1, wlen);
        m_second = code_eq(rx_char, held_off ? codes.off2 : codes.on2, wlen);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v    <= 1'b0;
            held_off  <= 1'b0;
            held_ch   <= '0;
            rep_v     <= 1'b0;
            rep_ch    <= '0;
            xoff_rcvd <= 1'b0;
            rx_push   <= 1'b0;
            rx_out    <= '0;
            rx_drop   <= 1'b0;
            spec_hit  <= 1'b0;
        end else begin
            rx_push  <= 1'b0;
            rx_drop  <= 1'b0;
            spec_hit <= 1'b0;
            if (rep_v) begin
                rx_push <= 1'b1;
                rx_out  <= rep_ch;
                rep_v   <= 1'b0;
            end
            if (rx_valid) begin
                if (spec_mode) begin
                    rx_push  <= 1'b1;
                    rx_out   <= rx_char;
                    spec_hit <= code_eq(rx_char, codes.off2, wlen);
                end else if (!flow_en) begin
                    rx_push <= 1'b1;
                    rx_out  <= rx_char;
                end else if (!dbl_mode) begin
                    if (m_off1) begin
                        xoff_rcvd <= 1'b1;
                        rx_drop   <= 1'b1;
                    end else if (m_on1) begin
                        xoff_rcvd <= 1'b0;
                        rx_drop   <= 1'b1;
                    end else begin
                        rx_push <= 1'b1;
                        rx_out  <= rx_char;
                    end
                end else if (held_v && m_second) begin
                    xoff_rcvd <= held_off;
                    rx_drop   <= 1'b1;
                    held_v    <= 1'b0;
                end else begin
                    if (held_v) begin
                        rx_push <= 1'b1;
                        rx_out  <= held_ch;
                    end
                    if (m_off1 || m_on1) begin
                        held_v   <= 1'b1;
                        held_off <= m_off1;
                        held_ch  <= rx_char;
                    end else if (held_v) begin
                        held_v <= 1'b0;
                        rep_v  <= 1'b1;
                        rep_ch <= rx_char;
                    end else begin
                        rx_push <= 1'b1;
                        rx_out  <= rx_char;
                    end
                end
            end
        end
    end

    AST_RX_SPACING: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R5
    AST_DROP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        rx_drop |-> !rx_push); // R6
    AST_SPEC_KEEPS: assert property (@(posedge clk) disable iff (rst)
        spec_hit |-> rx_push); // R7
    AST_RESUME_NEEDS_RX: assert property (@(posedge clk) disable iff (rst)
        $fell(xoff_rcvd) |-> $past(rx_valid)); // R3

endmodule

// File: rtl/xfc_tx_arb.sv
module xfc_tx_arb
    import xfc_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  codes_t           codes,
    input  logic             dbl_mode,
    input  logic             auto_xmit_en,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] trig_level,
    input  logic             xoff_rcvd,
    input  logic             tx_ready,
    input  logic             txq_valid,
    input  char_t            txq_char,
    output logic             tx_load,
    output char_t            tx_data,
    output logic             txq_pop,
    output logic             peer_paused
);

    inj_state_e st;
    logic       inj_off, busy, at_trig, q_go;
    char_t      inj_code;

    always_comb begin
        at_trig  = fifo_level >= trig_level;
        busy     = st != INJ_IDLE;
        inj_code = (st == INJ_SECOND) ? (inj_off ? codes.off2 : codes.on2)
                                      : (inj_off ? codes.off1 : codes.on1);
        q_go     = tx_ready && !busy && txq_valid && !xoff_rcvd;
        tx_load  = (tx_ready && busy) || q_go;
        txq_pop  = q_go;
        tx_data  = busy ? inj_code : txq_char;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= INJ_IDLE;
            inj_off     <= 1'b0;
            peer_paused <= 1'b0;
        end else begin
            case (st)
                INJ_IDLE: begin
                    if (auto_xmit_en && !peer_paused && at_trig) begin
                        st      <= INJ_FIRST;
                        inj_off <= 1'b1;
                    end else if (peer_paused && !at_trig) begin
                        st      <= INJ_FIRST;
                        inj_off <= 1'b0;
                    end
                end
                INJ_FIRST: begin
                    if (tx_ready) begin
                        if (dbl_mode) begin
                            st <= INJ_SECOND;
                        end else begin
                            st          <= INJ_IDLE;
                            peer_paused <= inj_off;
                        end
                    end
                end
                default: begin
                    if (tx_ready) begin
                        st          <= INJ_IDLE;
                        peer_paused <= inj_off;
                    end
                end
            endcase
        end
    end

    AST_NO_POP_SUSPENDED: assert property (@(posedge clk) disable iff (rst)
        xoff_rcvd |-> !txq_pop); // R3
    AST_INJ_BEFORE_QUEUE: assert property (@(posedge clk) disable iff (rst)
        txq_pop |-> (st == INJ_IDLE)); // R10
    AST_PAUSE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(peer_paused) |-> $past(tx_load)); // R9

endmodule

// File: rtl/xonxoff_flow_ctl.sv
module xonxoff_flow_ctl
    import xfc_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             code_we,
    input  logic [1:0]       code_sel,
    input  logic [7:0]       code_din,
    input  logic [1:0]       wlen,
    input  logic             flow_en,
    input  logic             dbl_mode,
    input  logic             spec_mode,
    input  logic             auto_xmit_en,
    input  logic             rx_valid,
    input  logic [7:0]       rx_char,
    output logic             rx_push,
    output logic [7:0]       rx_out,
    output logic             rx_drop,
    output logic             spec_hit,
    output logic             xoff_rcvd,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] trig_level,
    output logic             peer_paused,
    input  logic             tx_ready,
    input  logic             txq_valid,
    input  logic [7:0]       txq_char,
    output logic             tx_load,
    output logic [7:0]       tx_data,
    output logic             txq_pop
);

    codes_t codes;

    xfc_code_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (code_we),
        .sel   (code_sel),
        .din   (code_din),
        .codes (codes)
    );

    xfc_rx_match u_rx (
        .clk       (clk),
        .rst       (rst),
        .codes     (codes),
        .wlen      (wlen),
        .flow_en   (flow_en),
        .dbl_mode  (dbl_mode),
        .spec_mode (spec_mode),
        .rx_valid  (rx_valid),
        .rx_char   (rx_char),
        .rx_push   (rx_push),
        .rx_out    (rx_out),
        .rx_drop   (rx_drop),
        .spec_hit  (spec_hit),
        .xoff_rcvd (xoff_rcvd)
    );

    xfc_tx_arb #(.LVL_W(LVL_W)) u_tx (
        .clk          (clk),
        .rst          (rst),
        .codes        (codes),
        .dbl_mode     (dbl_mode),
        .auto_xmit_en (auto_xmit_en),
        .fifo_level   (fifo_level),
        .trig_level   (trig_level),
        .xoff_rcvd    (xoff_rcvd),
        .tx_ready     (tx_ready),
        .txq_valid    (txq_valid),
        .txq_char     (txq_char),
        .tx_load      (tx_load),
        .tx_data      (tx_data),
        .txq_pop      (txq_pop),
        .peer_paused  (peer_paused)
    );

endmodule

// File: tb/sim_xonxoff_flow_ctl.sv
module sim_xonxoff_flow_ctl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       code_we = 1'b0;
    logic [1:0] code_sel = '0;
    logic [7:0] code_din = '0;
    logic [1:0] wlen = 2'd3;
    logic       flow_en = 1'b0, dbl_mode = 1'b0, spec_mode = 1'b0, auto_xmit_en = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_push, rx_drop, spec_hit, xoff_rcvd, peer_paused;
    logic [7:0] rx_out, tx_data;
    logic [4:0] fifo_level = '0, trig_level = 5'd8;
    logic       tx_ready = 1'b0, txq_valid = 1'b0;
    logic [7:0] txq_char = '0;
    logic       tx_load, txq_pop;

    int n_chk = 0, n_bad = 0;
    logic [7:0] m_code [4];
    logic       m_held, m_off, m_xoff;
    logic [7:0] m_hch;

    xonxoff_flow_ctl u0 (.*);

    always #4 clk = ~clk;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic eqm(input logic [7:0] a, input logic [7:0] b, input logic [1:0] wl);
        logic [7:0] m;
        m = 8'((9'd1 << (5 + wl)) - 9'd1);
        return ((a ^ b) & m) == 8'h00;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) m_code[i] = 8'h00;
        m_held = 1'b0; m_off = 1'b0; m_xoff = 1'b0; m_hch = 8'h00;
    endtask

    task automatic wr_code(input int sel, input logic [7:0] v);
        @(negedge clk); code_we = 1'b1; code_sel = 2'(sel); code_din = v;
        @(negedge clk); code_we = 1'b0;
        m_code[sel] = v;
    endtask

    // m_code: 0 resume1, 1 resume2, 2 stop1, 3 stop2
    task automatic send_rx(input logic [7:0] ch, input string req);
        logic e1p, edr, esp, e2p;
        logic [7:0] e1d, e2d, sec;
        logic [20:0] exp_v, act_v;
        e1p = 0; edr = 0; esp = 0; e2p = 0; e1d = 0; e2d = 0;
        if (spec_mode) begin
            e1p = 1; e1d = ch; esp = eqm(ch, m_code[3], wlen);
        end else if (!flow_en) begin
            e1p = 1; e1d = ch;
        end else if (!dbl_mode) begin
            if (eqm(ch, m_code[2], wlen)) begin m_xoff = 1; edr = 1; end
            else if (eqm(ch, m_code[0], wlen)) begin m_xoff = 0; edr = 1; end
            else begin e1p = 1; e1d = ch; end
        end else begin
            sec = m_off ? m_code[3] : m_code[1];
            if (m_held && eqm(ch, sec, wlen)) begin
                m_xoff = m_off; edr = 1; m_held = 0;
            end else begin
                if (m_held) begin e1p = 1; e1d = m_hch; end
                if (eqm(ch, m_code[2], wlen)) begin m_held = 1; m_off = 1; m_hch = ch; end
                else if (eqm(ch, m_code[0], wlen)) begin m_held = 1; m_off = 0; m_hch = ch; end
                else if (m_held) begin m_held = 0; e2p = 1; e2d = ch; end
                else begin e1p = 1; e1d = ch; end
            end
        end
        @(negedge clk); rx_valid = 1'b1; rx_char = ch;
        @(negedge clk); rx_valid = 1'b0;
        act_v[20:10] = {xoff_rcvd, rx_push, rx_push ? rx_out : 8'h00, rx_drop};
        act_v[9]     = spec_hit;
        @(negedge clk);
        act_v[8:0] = {rx_push, rx_push ? rx_out : 8'h00};
        exp_v = {m_xoff, e1p, e1d, edr, esp, e2p, e2d};
        chk(act_v == exp_v, req, 32'(act_v), 32'(exp_v));
        @(negedge clk);
    endtask

    task automatic chk_tx(input logic ld, input logic [7:0] d, input logic pop, input string req);
        #1;
        chk(tx_load == ld && (!ld || tx_data == d) && txq_pop == pop, req,
            {22'd0, tx_load, tx_load ? tx_data : 8'h00, txq_pop},
            {22'd0, ld, ld ? d : 8'h00, pop});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        do_reset();
        #1;
        chk({xoff_rcvd, rx_push, rx_drop, peer_paused, tx_load} == 5'b0, "reset",
            {27'd0, xoff_rcvd, rx_push, rx_drop, peer_paused, tx_load}, 32'd0);
        // R1: zero codes after reset
        flow_en = 1;
        send_rx(8'h00, "R1 zero code matches");
        send_rx(8'h00 ^ 8'h00, "R1 zero code repeat");
        // R8: flow off passes everything
        do_reset(); flow_en = 0;
        wr_code(2, 8'h13);
        send_rx(8'h13, "R8 flow off passes");
        // R2 masking
        flow_en = 1; wlen = 2'd0;
        send_rx(8'hF3, "R2 5-bit match");
        wr_code(0, 8'h2C);
        send_rx(8'hEC, "R2 5-bit resume");
        wlen = 2'd3;
        send_rx(8'hF3, "R2 8-bit no match");
        // R3 suspension of queue
        send_rx(8'h13, "R3 stop");
        @(negedge clk); txq_valid = 1; txq_char = 8'hA5; tx_ready = 1;
        chk_tx(0, 8'h00, 0, "R3 queue held while suspended");
        send_rx(8'h44, "R3 data while suspended");
        chk_tx(0, 8'h00, 0, "R3 still held");
        send_rx(8'h2C, "R3 resume");
        chk_tx(1, 8'hA5, 1, "R3 queue released");
        @(negedge clk); tx_ready = 0; txq_valid = 0;
        // R4/R5 directed double mode
        dbl_mode = 1;
        wr_code(3, 8'h22); wr_code(0, 8'h33); wr_code(1, 8'h66);
        send_rx(8'h13, "R4 first stop held");
        send_rx(8'h22, "R4 stop pair");
        send_rx(8'h13, "R5 held");
        send_rx(8'h44, "R5 release with replay");
        send_rx(8'h13, "R5 held again");
        send_rx(8'h33, "R5 release, rehold resume");
        send_rx(8'h66, "R4 resume pair");
        send_rx(8'h22, "R6 lone second code is data");
        // R7 special mode
        spec_mode = 1;
        send_rx(8'h22, "R7 special hit kept");
        send_rx(8'h13, "R7 flow matching off");
        spec_mode = 0; dbl_mode = 0;
        // R9/R10 injection, double then single
        do_reset();
        wr_code(0, 8'h11); wr_code(1, 8'h12); wr_code(2, 8'h13); wr_code(3, 8'h14);
        dbl_mode = 1; auto_xmit_en = 1; trig_level = 5'd8; txq_valid = 1; txq_char = 8'h5A;
        @(negedge clk); fifo_level = 5'd8; tx_ready = 0;
        @(negedge clk);
        chk_tx(0, 8'h00, 0, "R10 no load without ready");
        tx_ready = 1;
        chk_tx(1, 8'h13, 0, "R10 stop1 ahead of queue");
        @(negedge clk); chk_tx(1, 8'h14, 0, "R10 stop2 second");
        @(negedge clk); chk_tx(1, 8'h5A, 1, "R10 queue after inject");
        chk(peer_paused == 1, "R9 paused set", {31'd0, peer_paused}, 1);
        tx_ready = 0; fifo_level = 5'd7;
        @(negedge clk); tx_ready = 1;
        chk_tx(1, 8'h11, 0, "R10 resume1");
        @(negedge clk); chk_tx(1, 8'h12, 0, "R10 resume2");
        @(negedge clk); #1;
        chk(peer_paused == 0, "R9 paused cleared", {31'd0, peer_paused}, 0);
        tx_ready = 0; dbl_mode = 0; fifo_level = 5'd20;
        @(negedge clk); tx_ready = 1;
        chk_tx(1, 8'h13, 0, "R10 single stop");
        @(negedge clk); #1;
        chk(peer_paused == 1, "R9 single paused", {31'd0, peer_paused}, 1);
        chk_tx(1, 8'h5A, 1, "R10 single one char only");
        tx_ready = 0; txq_valid = 0; auto_xmit_en = 0; fifo_level = 0;
        // random segments, R2 R4 R5 R6 R7 R8
        for (int seg = 0; seg < 8; seg++) begin
            do_reset();
            tx_ready = 0;
            for (int k = 0; k < 4; k++) wr_code(k, 8'($urandom));
            wlen = 2'($urandom); dbl_mode = 1'($urandom);
            spec_mode = ($urandom % 5) == 0; flow_en = ($urandom % 6) != 0;
            for (int n = 0; n < 40; n++) begin
                logic [7:0] c, hi;
                hi = ~(8'hFF >> (3 - wlen)) & 8'($urandom);
                if (($urandom % 4) != 0) c = m_code[$urandom % 4] ^ hi;
                else c = 8'($urandom);
                send_rx(c, "R5 random stream");
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule